// File: doc/BRIEF.md
# Page-Segmenting Serial EEPROM Write Sequencer

This block takes one write request (a start offset and a byte count) and programs a serial EEPROM through a byte-level SPI master. It reads the data from a valid/ready byte stream. Before any bus activity it checks the request against the device size. An offset past the end is refused. A count that runs off the end of the device is cut back to the device size.

The accepted range is split into segments that never cross a page boundary. For each segment the block first frames a stand-alone write-enable command. It then frames one write command that carries the opcode, the address and the segment data. After the write it polls the device status register until the device reports ready. When the device stays busy, the block gives up with a timeout error. The time limit applies only after a minimum number of poll attempts have been made.

The block does not drive SPI bits itself. It hands each byte to a shifter through a request/acknowledge pair and frames each command with a select output. When the last byte is programmed it pulses a completion output. If it refuses or aborts the request it pulses an error output, and a code gives the reason.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err` and `spi_sel` are 0 and `req_ready` is 1.
- R2: A request whose offset is greater than or equal to `DEV_SIZE` produces an `err` pulse with `err_code` = 1 and no SPI activity at all.
- R3: The count is clipped to `DEV_SIZE - offset`, and only that many bytes are taken from the data stream. A clipped count of zero produces an `err` pulse with `err_code` = 2 and no SPI activity.
- R4: Every write command is preceded by a separate select frame that holds the single byte 0x06. The select is deasserted for at least one cycle between the two frames.
- R5: A write frame is the opcode 0x02, then `ADDR_BYTES` address bytes (most significant byte first), then the segment data, all inside one select frame.
- R6: The length of a segment is `PAGE_SIZE - (offset mod PAGE_SIZE)`, limited to the bytes that remain. The next segment starts at the following offset.
- R7: When `ADDR9` is set, `ADDR_BYTES` is 1 and the segment offset is 256 or more, the opcode is 0x0A and the address byte carries the low 8 bits of the offset.
- R8: After each write frame the block sends frames of 0x05 followed by one dummy byte, and reads bit 0 of the second returned byte. It repeats while that bit is 1. When the bit is 0 it starts the next segment, or pulses `done` if no bytes remain.
- R9: While the device stays busy, polling stops only when at least `MIN_POLLS` busy reads have been made and more than `CLK_HZ*TIMEOUT_MS/1000` cycles have passed since polling began. The block then pulses `err` with `err_code` = 3 and starts no further segment.
- R10: Between two consecutive poll frames the select stays low for at least `POLL_GAP` cycles.
- R11: `spi_req` is only high inside a select frame and holds `spi_tx` stable until `spi_ack`. A data byte is taken from the stream (`wr_ready`) only in the cycle its byte is acknowledged.
- R12: `done` and `err` are one-cycle pulses, are never high together, and are raised with the block already idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_offset | input | OFS_W | Start byte offset |
| req_count | input | OFS_W | Number of bytes to write |
| wr_data | input | 8 | Write data byte stream |
| wr_valid | input | 1 | Stream byte valid |
| wr_ready | output | 1 | Stream byte taken this cycle |
| spi_sel | output | 1 | Command frame select (high = device selected) |
| spi_req | output | 1 | Byte transfer request to the shifter |
| spi_tx | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Shifter finished the current byte |
| spi_rx | input | 8 | Byte shifted in, valid with `spi_ack` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Pulse: request finished without error |
| err | output | 1 | Pulse: request refused or aborted |
| err_code | output | 2 | Reason of the last error: 1 range, 2 empty, 3 timeout |

## Verification
The bench builds the block for a 512-byte device with 16-byte pages, one address byte, the ninth-address-bit option on, a minimum of 3 polls and a 16-cycle poll gap. A clock rate of 1000 Hz makes the 25 ms limit only 25 cycles. With these values a write that crosses a page and a clip at the end of the device need only a few bytes. They also bring the opcode bit for offsets above 255 within reach. Because a single poll round takes about 22 cycles, the time limit expires before the third busy read. A device that never becomes ready therefore shows that the minimum poll count, and not the clock, decides when the block aborts.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WREN,
        ST_SEP_A,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_SEP_B,
        ST_POLL_CMD,
        ST_POLL_RD,
        ST_POLL_WAIT,
        ST_NEXT
    } state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_RANGE   = 2'd1,
        ERR_EMPTY   = 2'd2,
        ERR_TIMEOUT = 2'd3
    } err_e;

    localparam logic [7:0] OP_WEN    = 8'h06;
    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_A8_BIT = 8'h08;
    localparam logic [7:0] DUMMY     = 8'h00;

endpackage

// File: rtl/eepw_req_check.sv
module eepw_req_check #(
    parameter int OFS_W    = 24,
    parameter int DEV_SIZE = 32768
) (
    input  logic [OFS_W-1:0] offset,
    input  logic [OFS_W-1:0] count,
    output logic             out_of_range,
    output logic             empty,
    output logic [OFS_W:0]   count_eff
);
    localparam int CNT_W = OFS_W + 1;

    logic [CNT_W-1:0] room;

    always_comb begin
        out_of_range = {1'b0, offset} >= CNT_W'(DEV_SIZE);
        room         = out_of_range ? '0 : (CNT_W'(DEV_SIZE) - {1'b0, offset});
        count_eff    = ({1'b0, count} > room) ? room : {1'b0, count};
        empty        = (count_eff == '0);
    end
endmodule

// File: rtl/eepw_seg_calc.sv
module eepw_seg_calc #(
    parameter int OFS_W      = 24,
    parameter int PAGE_SIZE  = 64,
    parameter int ADDR_BYTES = 2,
    parameter int ADDR9      = 0
) (
    input  logic [OFS_W-1:0]              ofs,
    input  logic [OFS_W:0]                rem,
    input  logic [1:0]                    aidx,
    output logic [$clog2(PAGE_SIZE):0]    seg_len,
    output logic [7:0]                    wr_opcode,
    output logic [7:0]                    addr_byte
);
    import eepw_pkg::*;

    localparam int PG_W  = $clog2(PAGE_SIZE);
    localparam int SEG_W = PG_W + 1;
    localparam int CNT_W = OFS_W + 1;
    localparam int EXT_W = OFS_W + 24;

    logic [SEG_W-1:0] room;
    logic [EXT_W-1:0] ext;
    int               sh;

    always_comb begin
        room    = SEG_W'(PAGE_SIZE) - {1'b0, ofs[PG_W-1:0]};
        seg_len = (CNT_W'(room) > rem) ? SEG_W'(rem) : room;

        wr_opcode = OP_WRITE;
        if (ADDR9 != 0 && ADDR_BYTES == 1 && {1'b0, ofs} >= CNT_W'(256))
            wr_opcode = OP_WRITE | OP_A8_BIT;

        ext = EXT_W'(ofs);
        sh  = ADDR_BYTES - 1 - int'(aidx);
        if (sh < 0) sh = 0;
        addr_byte = ext[8*sh +: 8];
    end
endmodule

// File: rtl/eepw_poll_timer.sv
module eepw_poll_timer #(
    parameter int LIMIT_CYC = 25,
    parameter int POLL_GAP  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic gap_load,
    output logic expired,
    output logic gap_done
);
    localparam int EL_W  = $clog2(LIMIT_CYC + 2) + 1;
    localparam int GAP_W = $clog2(POLL_GAP + 1) + 1;

    logic [EL_W-1:0]  elapsed_d, elapsed_q;
    logic [GAP_W-1:0] gap_d, gap_q;

    always_comb begin
        elapsed_d = elapsed_q;
        if (restart)
            elapsed_d = '0;
        else if (elapsed_q <= EL_W'(LIMIT_CYC))
            elapsed_d = elapsed_q + 1'b1;

        gap_d = gap_q;
        if (gap_load)
            gap_d = GAP_W'(POLL_GAP);
        else if (gap_q != '0)
            gap_d = gap_q - 1'b1;

        expired  = elapsed_q > EL_W'(LIMIT_CYC);
        gap_done = gap_q <= GAP_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            gap_q     <= '0;
        end else begin
            elapsed_q <= elapsed_d;
            gap_q     <= gap_d;
        end
    end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
    parameter int OFS_W      = 24,
    parameter int DEV_SIZE   = 32768,
    parameter int PAGE_SIZE  = 64,
    parameter int ADDR_BYTES = 2,
    parameter int ADDR9      = 0,
    parameter int CLK_HZ     = 200_000_000,
    parameter int TIMEOUT_MS = 25,
    parameter int MIN_POLLS  = 3,
    parameter int POLL_GAP   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [OFS_W-1:0] req_offset,
    input  logic [OFS_W-1:0] req_count,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic             spi_sel,
    output logic             spi_req,
    output logic [7:0]       spi_tx,
    input  logic             spi_ack,
    input  logic [7:0]       spi_rx,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [1:0]       err_code
);
    import eepw_pkg::*;

    localparam int CNT_W     = OFS_W + 1;
    localparam int SEG_W     = $clog2(PAGE_SIZE) + 1;
    localparam int TRY_W     = $clog2(MIN_POLLS + 1) + 1;
    localparam int LIMIT_CYC = int'((longint'(CLK_HZ) * longint'(TIMEOUT_MS)) / 64'd1000);

    typedef struct packed {
        state_e           st;
        logic [OFS_W-1:0] ofs;
        logic [CNT_W-1:0] rem;
        logic [SEG_W-1:0] seg_left;
        logic [1:0]       aidx;
        logic [TRY_W-1:0] tries;
        err_e             code;
        logic             done;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;

    logic             bad_range, bad_empty;
    logic [CNT_W-1:0] cnt_eff;
    logic [SEG_W-1:0] seg_len;
    logic [7:0]       wr_opcode, addr_byte;
    logic             tmr_restart, gap_load, expired, gap_done;
    logic [TRY_W-1:0] tries_inc;
    logic             unused_rx;

    assign unused_rx = ^spi_rx[7:1];

    eepw_req_check #(.OFS_W(OFS_W), .DEV_SIZE(DEV_SIZE)) u_req_check (
        .offset       (req_offset),
        .count        (req_count),
        .out_of_range (bad_range),
        .empty        (bad_empty),
        .count_eff    (cnt_eff)
    );

    eepw_seg_calc #(
        .OFS_W(OFS_W), .PAGE_SIZE(PAGE_SIZE),
        .ADDR_BYTES(ADDR_BYTES), .ADDR9(ADDR9)
    ) u_seg_calc (
        .ofs       (r_q.ofs),
        .rem       (r_q.rem),
        .aidx      (r_q.aidx),
        .seg_len   (seg_len),
        .wr_opcode (wr_opcode),
        .addr_byte (addr_byte)
    );

    eepw_poll_timer #(.LIMIT_CYC(LIMIT_CYC), .POLL_GAP(POLL_GAP)) u_poll_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (tmr_restart),
        .gap_load (gap_load),
        .expired  (expired),
        .gap_done (gap_done)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        req_ready   = 1'b0;
        wr_ready    = 1'b0;
        spi_sel     = 1'b0;
        spi_req     = 1'b0;
        spi_tx      = DUMMY;
        tmr_restart = 1'b0;
        gap_load    = 1'b0;
        tries_inc   = (r_q.tries == '1) ? r_q.tries : r_q.tries + 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (bad_range) begin
                        r_d.err  = 1'b1;
                        r_d.code = ERR_RANGE;
                    end else if (bad_empty) begin
                        r_d.err  = 1'b1;
                        r_d.code = ERR_EMPTY;
                    end else begin
                        r_d.code = ERR_NONE;
                        r_d.ofs  = req_offset;
                        r_d.rem  = cnt_eff;
                        r_d.st   = ST_WREN;
                    end
                end
            end
            ST_WREN: begin
                spi_sel = 1'b1;
                spi_req = 1'b1;
                spi_tx  = OP_WEN;
                if (spi_ack) r_d.st = ST_SEP_A;
            end
            ST_SEP_A: r_d.st = ST_CMD;
            ST_CMD: begin
                spi_sel = 1'b1;
                spi_req = 1'b1;
                spi_tx  = wr_opcode;
                if (spi_ack) begin
                    r_d.seg_left = seg_len;
                    r_d.aidx     = '0;
                    r_d.st       = ST_ADDR;
                end
            end
            ST_ADDR: begin
                spi_sel = 1'b1;
                spi_req = 1'b1;
                spi_tx  = addr_byte;
                if (spi_ack) begin
                    if (int'(r_q.aidx) == ADDR_BYTES - 1) r_d.st = ST_DATA;
                    else                                   r_d.aidx = r_q.aidx + 1'b1;
                end
            end
            ST_DATA: begin
                spi_sel  = 1'b1;
                spi_req  = wr_valid;
                spi_tx   = wr_data;
                wr_ready = spi_ack;
                if (spi_ack) begin
                    r_d.ofs      = r_q.ofs + 1'b1;
                    r_d.rem      = r_q.rem - 1'b1;
                    r_d.seg_left = r_q.seg_left - 1'b1;
                    if (r_q.seg_left == SEG_W'(1)) r_d.st = ST_SEP_B;
                end
            end
            ST_SEP_B: begin
                tmr_restart = 1'b1;
                r_d.tries   = '0;
                r_d.st      = ST_POLL_CMD;
            end
            ST_POLL_CMD: begin
                spi_sel = 1'b1;
                spi_req = 1'b1;
                spi_tx  = OP_STATUS;
                if (spi_ack) r_d.st = ST_POLL_RD;
            end
            ST_POLL_RD: begin
                spi_sel = 1'b1;
                spi_req = 1'b1;
                spi_tx  = DUMMY;
                if (spi_ack) begin
                    if (!spi_rx[0]) begin
                        r_d.st = ST_NEXT;
                    end else begin
                        r_d.tries = tries_inc;
                        if (tries_inc < TRY_W'(MIN_POLLS) || !expired) begin
                            gap_load = 1'b1;
                            r_d.st   = ST_POLL_WAIT;
                        end else begin
                            r_d.err  = 1'b1;
                            r_d.code = ERR_TIMEOUT;
                            r_d.st   = ST_IDLE;
                        end
                    end
                end
            end
            ST_POLL_WAIT: if (gap_done) r_d.st = ST_POLL_CMD;
            ST_NEXT: begin
                if (r_q.rem == '0) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.st = ST_WREN;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, code: ERR_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign err_code = r_q.code;

endmodule

module eeprom_page_writer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       wr_ready,
    input logic       spi_sel,
    input logic       spi_req,
    input logic [7:0] spi_tx,
    input logic       spi_ack,
    input logic       busy,
    input logic       done,
    input logic       err
);
    // R11
    req_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_req |-> spi_sel);
    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));
    // R11
    data_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (spi_ack && spi_req));
    // R12
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy || err));
    // R1
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !spi_sel);
endmodule

bind eeprom_page_writer eeprom_page_writer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .wr_ready(wr_ready), .spi_sel(spi_sel), .spi_req(spi_req), .spi_tx(spi_tx),
    .spi_ack(spi_ack), .busy(busy), .done(done), .err(err)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
    localparam int OFS_W = 12;
    localparam int GAP   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [OFS_W-1:0] req_offset = '0;
    logic [OFS_W-1:0] req_count = '0;
    logic [7:0] wr_data;
    logic wr_valid = 1'b1;
    logic wr_ready;
    logic spi_sel, spi_req;
    logic [7:0] spi_tx;
    logic spi_ack = 1'b0;
    logic [7:0] spi_rx = 8'h00;
    logic busy, done, err;
    logic [1:0] err_code;

    always #2.5 clk = ~clk;

    eeprom_page_writer #(
        .OFS_W(OFS_W), .DEV_SIZE(512), .PAGE_SIZE(16), .ADDR_BYTES(1), .ADDR9(1),
        .CLK_HZ(1000), .TIMEOUT_MS(25), .MIN_POLLS(3), .POLL_GAP(GAP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_count(req_count), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .spi_sel(spi_sel),
        .spi_req(spi_req), .spi_tx(spi_tx), .spi_ack(spi_ack), .spi_rx(spi_rx),
        .busy(busy), .done(done), .err(err), .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;

    // data stream
    int consumed = 0;
    always @(posedge clk) if (wr_valid && wr_ready) consumed <= consumed + 1;
    assign wr_data = 8'(consumed) ^ 8'h5A;

    // device model
    logic       mdl_clr = 1'b0;
    int         busy_cfg = 0;
    bit         busy_forever = 1'b0;
    logic [7:0] mem [0:511];
    logic [7:0] fr [0:31];
    int         fidx, n_wren, n_write, n_poll, bad_write, lowrun, start_run, min_gap, busy_left;
    bit         wel, sel_q, ackw, last_poll;
    logic [7:0] w_op [0:7];
    logic [7:0] w_addr [0:7];
    int         w_len [0:7];

    always @(posedge clk) begin
        if (mdl_clr) begin
            fidx <= 0; n_wren <= 0; n_write <= 0; n_poll <= 0; bad_write <= 0;
            lowrun <= 0; start_run <= 0; min_gap <= 1000; busy_left <= 0;
            wel <= 0; sel_q <= 0; ackw <= 0; last_poll <= 0; spi_ack <= 0;
        end else begin
            sel_q   <= spi_sel;
            spi_ack <= 1'b0;
            if (!spi_sel) lowrun <= lowrun + 1;
            if (spi_sel && !sel_q) begin
                fidx <= 0;
                start_run <= lowrun;
                lowrun <= 0;
            end
            if (spi_req && !spi_ack) begin
                if (!ackw) ackw <= 1'b1;
                else begin
                    ackw    <= 1'b0;
                    spi_ack <= 1'b1;
                    fr[fidx[4:0]] <= spi_tx;
                    fidx    <= fidx + 1;
                    spi_rx  <= (fidx == 1 && fr[0] == 8'h05) ?
                               {7'b0, (busy_forever || busy_left > 0)} : 8'h00;
                end
            end
            if (!spi_sel && sel_q) begin
                last_poll <= 1'b0;
                if (fr[0] == 8'h06) begin
                    wel <= 1'b1; n_wren <= n_wren + 1;
                end else if (fr[0] == 8'h05) begin
                    n_poll <= n_poll + 1;
                    last_poll <= 1'b1;
                    if (last_poll && start_run < min_gap) min_gap <= start_run;
                    if (busy_left > 0) busy_left <= busy_left - 1;
                end else if (fr[0] == 8'h02 || fr[0] == 8'h0A) begin
                    if (!wel) bad_write <= bad_write + 1;
                    else begin
                        automatic logic [8:0] a = {fr[0][3], fr[1]};
                        for (int i = 2; i < fidx; i++)
                            mem[{a[8:4], 4'(a[3:0] + 4'(i - 2))}] <= fr[i];
                        wel <= 1'b0;
                        busy_left <= busy_cfg;
                        w_op[n_write[2:0]]   <= fr[0];
                        w_addr[n_write[2:0]] <= fr[1];
                        w_len[n_write[2:0]]  <= fidx;
                        n_write <= n_write + 1;
                    end
                end
            end
        end
    end

    // global watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp fewer than 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    bit got_done, got_err;
    int got_code;

    task automatic clear_model(input int bcfg, input bit bfor);
        busy_cfg = bcfg;
        busy_forever = bfor;
        @(negedge clk) mdl_clr = 1'b1;
        @(negedge clk) mdl_clr = 1'b0;
    endtask

    task automatic run_req(input int ofs, input int cnt);
        int w;
        @(negedge clk);
        req_offset = OFS_W'(ofs);
        req_count  = OFS_W'(cnt);
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        got_done = 0; got_err = 0; got_code = 0;
        w = 0;
        while (!(done || err) && w < 5000) begin
            @(negedge clk);
            w++;
        end
        got_done = done; got_err = err; got_code = int'(err_code);
        if (w >= 5000) chk(0, "R12 watchdog", w, 5000);
        @(negedge clk);
        // R12 single-cycle pulse
        chk(!done && !err, "R12 pulse", int'(done) + int'(err), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_mem(input int ofs, input int n, input int base, input string req);
        for (int i = 0; i < n; i++) begin
            automatic logic [7:0] e = 8'(base + i) ^ 8'h5A;
            if (mem[ofs + i] !== e) begin
                chk(0, req, int'(mem[ofs + i]), int'(e));
                return;
            end
        end
        chk(1, req, 0, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!busy && !done && !err && !spi_sel && req_ready, "R1 reset state",
            {busy, done, err, spi_sel, req_ready}, 1);
    endtask

    task automatic t_single;
        int base;
        clear_model(0, 0);
        base = consumed;
        run_req(5, 4);
        chk(got_done, "R8 done single", int'(got_done), 1);
        chk(n_wren == 1 && bad_write == 0, "R4 wren before write", n_wren, 1);
        chk(n_write == 1, "R5 one write frame", n_write, 1);
        chk(w_op[0] == 8'h02, "R5 opcode", int'(w_op[0]), 2);
        chk(w_addr[0] == 8'h05, "R5 address byte", int'(w_addr[0]), 5);
        chk(w_len[0] == 6, "R5 frame length", w_len[0], 6);
        check_mem(5, 4, base, "R5 data");
        chk(consumed - base == 4, "R11 bytes taken", consumed - base, 4);
    endtask

    task automatic t_cross;
        int base;
        clear_model(1, 0);
        base = consumed;
        run_req(12, 10);
        chk(got_done, "R8 done cross", int'(got_done), 1);
        chk(n_write == 2, "R6 segment count", n_write, 2);
        chk(w_len[0] == 6, "R6 first segment", w_len[0], 6);
        chk(w_len[1] == 8 && w_addr[1] == 8'h10, "R6 second segment", w_len[1], 8);
        chk(n_wren == 2 && bad_write == 0, "R4 wren per segment", n_wren, 2);
        chk(n_poll == 4, "R8 poll busy then ready", n_poll, 4);
        chk(min_gap >= GAP, "R10 poll gap", min_gap, GAP);
        check_mem(12, 10, base, "R6 data");
    endtask

    task automatic t_ninth;
        int base;
        clear_model(0, 0);
        base = consumed;
        run_req(300, 3);
        chk(got_done, "R7 done", int'(got_done), 1);
        chk(w_op[0] == 8'h0A, "R7 opcode bit3", int'(w_op[0]), 10);
        chk(w_addr[0] == 8'h2C, "R7 low address", int'(w_addr[0]), 44);
        check_mem(300, 3, base, "R7 data");
    endtask

    task automatic t_trunc;
        int base;
        clear_model(0, 0);
        base = consumed;
        run_req(508, 10);
        chk(got_done, "R3 done truncated", int'(got_done), 1);
        chk(consumed - base == 4, "R3 clipped count", consumed - base, 4);
        chk(w_len[0] == 6, "R3 clipped frame", w_len[0], 6);
        check_mem(508, 4, base, "R3 data");
    endtask

    task automatic t_reject;
        clear_model(0, 0);
        run_req(512, 4);
        chk(got_err && got_code == 1, "R2 offset at size", got_code, 1);
        run_req(700, 1);
        chk(got_err && got_code == 1, "R2 offset beyond", got_code, 1);
        run_req(10, 0);
        chk(got_err && got_code == 2, "R3 zero count", got_code, 2);
        chk(n_wren + n_write + n_poll == 0, "R2 no spi activity", n_wren + n_write + n_poll, 0);
    endtask

    task automatic t_timeout;
        clear_model(0, 1);
        run_req(0, 20);
        chk(got_err && got_code == 3, "R9 timeout code", got_code, 3);
        chk(n_poll == 3, "R9 minimum polls", n_poll, 3);
        chk(n_write == 1, "R9 no further segment", n_write, 1);
        chk(!busy, "R9 idle after abort", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        mdl_clr = 1'b1;
        repeat (3) @(negedge clk);
        mdl_clr = 1'b0;
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_cross();
        t_ninth();
        t_trunc();
        t_reject();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule